// File: doc/BRIEF.md
# Context Memory Loop Sequencer

This block is a small microcoded controller. It steps through instruction words held in a local context memory. Each word either sends one configuration word to a register file, an arithmetic datapath unit or an interconnect switch, or it steers the flow of execution. The block does not run a general program. It runs the configuration schedule of one tile, and its loops and branches are evaluated in hardware with no software in the path.

A host fills the context memory through a simple write port, then pulses `start`. The sequencer begins at address 0 and executes one instruction per clock. It can branch on one of several external status flags, and it can run counted loops nested two deep. It can also stall for a programmed number of cycles. When it reaches a halt instruction it raises `done`, which stays high until the next start.

Top module: `ctx_seq`

## Requirements
- R1: Instruction words are 32 bits, and the opcode sits in bits [31:29]: 0 halt, 1 register-file config, 2 datapath config, 3 switch config, 4 branch, 5 loop, 6 loop end, 7 wait. A write on the load port stores `ld_word` at `ld_addr`.
- R2: In the running state the block executes one instruction per cycle in address order. The address wraps from 31 to 0.
- R3: Opcodes 1, 2 and 3 copy bits [15:0] onto `rf_word`, `dpu_word` or `sw_word` respectively. The matching strobe is high for exactly the one cycle after the instruction executes. At most one strobe is high in any cycle.
- R4: A branch (opcode 4) reads a flag index from bits [9:8], a polarity from bit 12 and a target from bits [4:0]. It jumps to the target when the selected flag equals the polarity. Otherwise it falls through.
- R5: A loop (opcode 5) pushes the next address and the count in bits [23:16]. The body up to the matching loop end then runs max(count,1) times, at 2 cycles per iteration for a one-instruction body.
- R6: A loop end (opcode 6) jumps back to the stored start address while the stored count is above 1, decrementing the count each time. Otherwise it pops the entry. On an empty stack it simply falls through.
- R7: Loops nest two deep, and the stack level never exceeds two.
- R8: A wait (opcode 7) with a value N in bits [15:0] delays the next instruction by N extra cycles. N = 0 adds no delay.
- R9: A halt (opcode 0) raises `done` one cycle later. `done` holds, with no strobes, until `start`. `start` clears `done` and restarts execution at address 0.
- R10: `start` is ignored while a program is running or waiting.
- R11: After reset the block is idle, with all strobes and `done` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Context memory write enable |
| ld_addr | input | 5 | Context memory write address |
| ld_word | input | 32 | Instruction word to store |
| start | input | 1 | Begin execution at address 0 |
| flags | input | 4 | Status flags for conditional branches |
| rf_word | output | 16 | Register-file configuration word |
| rf_stb | output | 1 | Register-file word valid |
| dpu_word | output | 16 | Datapath configuration word |
| dpu_stb | output | 1 | Datapath word valid |
| sw_word | output | 16 | Switch configuration word |
| sw_stb | output | 1 | Switch word valid |
| done | output | 1 | Program reached halt |

## Verification
The bench sweeps loop counts 0 to 5 and checks the iteration and cycle totals. A decoder that treats a count of 0 as 256, or that runs the body one time too many, shows up in those totals. It crosses every flag index, both polarities and all 16 flag patterns, so an inverted polarity or a wrong flag select sends execution down the wrong path. Nested counts from 1 to 3 expose a stack that lets the inner loop end pop or decrement the outer entry. The bench also checks wait lengths including zero, a loop end on an empty stack, a program that wraps from address 31 to 0, and a start pulse during a wait. A design that restarts on that pulse shifts every later strobe.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
    localparam int INSTR_W  = 32;
    localparam int OP_LSB   = 29;
    localparam int LCNT_W   = 8;
    localparam int LCNT_LSB = 16;
    localparam int WAIT_W   = 16;
    localparam int SEL_LSB  = 8;
    localparam int POL_BIT  = 12;

    typedef enum logic [2:0] {
        OP_HALT = 3'd0,
        OP_RF   = 3'd1,
        OP_DPU  = 3'd2,
        OP_SW   = 3'd3,
        OP_BR   = 3'd4,
        OP_LOOP = 3'd5,
        OP_LEND = 3'd6,
        OP_WAIT = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_WAIT,
        ST_DONE
    } st_e;

    function automatic op_e get_op(input logic [INSTR_W-1:0] w);
        return op_e'(w[INSTR_W-1:OP_LSB]);
    endfunction

    function automatic logic [LCNT_W-1:0] get_lcnt(input logic [INSTR_W-1:0] w);
        return w[LCNT_LSB +: LCNT_W];
    endfunction

    function automatic logic [WAIT_W-1:0] get_wait(input logic [INSTR_W-1:0] w);
        return w[WAIT_W-1:0];
    endfunction
endpackage

// File: rtl/ctx_mem.sv
module ctx_mem #(
    parameter int DEPTH = 32,
    parameter int W     = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/loop_stack.sv
module loop_stack #(
    parameter int LEVELS = 2,
    parameter int AW     = 5,
    parameter int CW     = 8,
    parameter int LW     = $clog2(LEVELS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic          dec,
    input  logic [AW-1:0] push_pc,
    input  logic [CW-1:0] push_cnt,
    output logic [AW-1:0] top_pc,
    output logic [CW-1:0] top_cnt,
    output logic          empty,
    output logic [LW-1:0] level
);
    localparam int IDX_W = $clog2(LEVELS);

    logic [AW-1:0]    pcs  [LEVELS];
    logic [CW-1:0]    cnts [LEVELS];
    logic [LW-1:0]    lvl;
    logic [LW-1:0]    lvl_m1;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] top_idx;
    logic             full;

    assign lvl_m1  = lvl - 1'b1;
    assign wr_idx  = lvl[IDX_W-1:0];
    assign top_idx = lvl_m1[IDX_W-1:0];
    assign full    = (lvl == LW'(LEVELS));
    assign empty   = (lvl == '0);
    assign level   = lvl;
    assign top_pc  = pcs[top_idx];
    assign top_cnt = cnts[top_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl <= '0;
        end else if (push && !full) begin
            lvl <= lvl + 1'b1;
        end else if (pop && !empty) begin
            lvl <= lvl_m1;
        end
    end

    for (genvar g = 0; g < LEVELS; g++) begin : g_ent
        logic [AW-1:0] e_pc;
        logic [CW-1:0] e_cnt;
        always_ff @(posedge clk) begin
            if (push && !full && wr_idx == IDX_W'(g)) begin
                e_pc  <= push_pc;
                e_cnt <= push_cnt;
            end else if (dec && !empty && top_idx == IDX_W'(g)) begin
                e_cnt <= e_cnt - 1'b1;
            end
        end
        assign pcs[g]  = e_pc;
        assign cnts[g] = e_cnt;
    end
endmodule

// File: rtl/ctx_seq.sv
module ctx_seq
    import ctx_seq_pkg::*;
#(
    parameter int DEPTH       = 32,
    parameter int CFG_W       = 16,
    parameter int NFLAG       = 4,
    parameter int LOOP_LEVELS = 2,
    parameter int AW          = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ld_en,
    input  logic [AW-1:0]      ld_addr,
    input  logic [INSTR_W-1:0] ld_word,
    input  logic               start,
    input  logic [NFLAG-1:0]   flags,
    output logic [CFG_W-1:0]   rf_word,
    output logic               rf_stb,
    output logic [CFG_W-1:0]   dpu_word,
    output logic               dpu_stb,
    output logic [CFG_W-1:0]   sw_word,
    output logic               sw_stb,
    output logic               done
);
    localparam int SEL_W = (NFLAG > 1) ? $clog2(NFLAG) : 1;
    localparam int LVL_W = $clog2(LOOP_LEVELS + 1);

    st_e                st;
    logic [AW-1:0]      pc;
    logic [AW-1:0]      pc_inc;
    logic [WAIT_W-1:0]  wcnt;
    logic [INSTR_W-1:0] instr;
    op_e                op;
    logic               run;
    logic               st_push, st_pop, st_dec, lend;
    logic [AW-1:0]      top_pc;
    logic [LCNT_W-1:0]  top_cnt;
    logic               st_empty;
    logic [LVL_W-1:0]   stk_lvl;
    logic [SEL_W-1:0]   fsel;
    logic               br_taken;

    ctx_mem #(.DEPTH(DEPTH), .W(INSTR_W), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (ld_en),
        .waddr (ld_addr),
        .wdata (ld_word),
        .raddr (pc),
        .rdata (instr)
    );

    loop_stack #(.LEVELS(LOOP_LEVELS), .AW(AW), .CW(LCNT_W), .LW(LVL_W)) u_stk (
        .clk      (clk),
        .rst      (rst),
        .push     (st_push),
        .pop      (st_pop),
        .dec      (st_dec),
        .push_pc  (pc_inc),
        .push_cnt (get_lcnt(instr)),
        .top_pc   (top_pc),
        .top_cnt  (top_cnt),
        .empty    (st_empty),
        .level    (stk_lvl)
    );

    always_comb begin
        op       = get_op(instr);
        run      = (st == ST_RUN);
        pc_inc   = pc + 1'b1;
        lend     = run && (op == OP_LEND) && !st_empty;
        st_push  = run && (op == OP_LOOP);
        st_dec   = lend && (top_cnt > LCNT_W'(1));
        st_pop   = lend && (top_cnt <= LCNT_W'(1));
        fsel     = instr[SEL_LSB +: SEL_W];
        br_taken = (flags[fsel] == instr[POL_BIT]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            pc       <= '0;
            wcnt     <= '0;
            done     <= 1'b0;
            rf_word  <= '0;
            dpu_word <= '0;
            sw_word  <= '0;
            rf_stb   <= 1'b0;
            dpu_stb  <= 1'b0;
            sw_stb   <= 1'b0;
        end else begin
            rf_stb  <= 1'b0;
            dpu_stb <= 1'b0;
            sw_stb  <= 1'b0;
            case (st)
                ST_IDLE, ST_DONE: begin
                    if (start) begin
                        st   <= ST_RUN;
                        pc   <= '0;
                        done <= 1'b0;
                    end
                end
                ST_RUN: begin
                    case (op)
                        OP_HALT: begin
                            st   <= ST_DONE;
                            done <= 1'b1;
                        end
                        OP_RF: begin
                            rf_word <= instr[CFG_W-1:0];
                            rf_stb  <= 1'b1;
                            pc      <= pc_inc;
                        end
                        OP_DPU: begin
                            dpu_word <= instr[CFG_W-1:0];
                            dpu_stb  <= 1'b1;
                            pc       <= pc_inc;
                        end
                        OP_SW: begin
                            sw_word <= instr[CFG_W-1:0];
                            sw_stb  <= 1'b1;
                            pc      <= pc_inc;
                        end
                        OP_BR:   pc <= br_taken ? instr[AW-1:0] : pc_inc;
                        OP_LOOP: pc <= pc_inc;
                        OP_LEND: pc <= st_dec ? top_pc : pc_inc;
                        OP_WAIT: begin
                            if (get_wait(instr) == '0) begin
                                pc <= pc_inc;
                            end else begin
                                wcnt <= get_wait(instr);
                                st   <= ST_WAIT;
                            end
                        end
                        default: pc <= pc_inc;
                    endcase
                end
                ST_WAIT: begin
                    if (wcnt == WAIT_W'(1)) begin
                        st <= ST_RUN;
                        pc <= pc_inc;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ctx_seq_chk.sv
module ctx_seq_chk #(
    parameter int LEVELS = 2,
    parameter int LW     = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          rf_stb,
    input logic          dpu_stb,
    input logic          sw_stb,
    input logic          done,
    input logic [LW-1:0] lvl
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rf_stb, dpu_stb, sw_stb})); // R3

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        done |-> !(rf_stb || dpu_stb || sw_stb)); // R9

    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done); // R9

    AST_STACK_BOUND: assert property (@(posedge clk) disable iff (rst)
        lvl <= LW'(LEVELS)); // R7

    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> !(done || rf_stb || dpu_stb || sw_stb)); // R11
endmodule

bind ctx_seq ctx_seq_chk #(.LEVELS(LOOP_LEVELS), .LW(LVL_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .rf_stb  (rf_stb),
    .dpu_stb (dpu_stb),
    .sw_stb  (sw_stb),
    .done    (done),
    .lvl     (stk_lvl)
);

// File: tb/ctx_seq_test.sv
module ctx_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic [4:0]  ld_addr = '0;
    logic [31:0] ld_word = '0;
    logic        start = 1'b0;
    logic [3:0]  flags = '0;
    logic [15:0] rf_word, dpu_word, sw_word;
    logic        rf_stb, dpu_stb, sw_stb, done;

    int errors = 0;
    int checks = 0;
    int cyc, n_rf, n_dpu, n_sw, rf_t1, rf_t2, dpu_t1, sw_t1, done_t;
    logic [15:0] last_rf, last_dpu, last_sw;

    ctx_seq uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
        .start(start), .flags(flags), .rf_word(rf_word), .rf_stb(rf_stb),
        .dpu_word(dpu_word), .dpu_stb(dpu_stb), .sw_word(sw_word), .sw_stb(sw_stb),
        .done(done)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] i_cfg(input int op, input int v);
        return (32'(op) << 29) | 32'(v & 16'hFFFF);
    endfunction
    function automatic logic [31:0] i_br(input int sel, input int pol, input int tgt);
        return (32'd4 << 29) | (32'(pol) << 12) | (32'(sel) << 8) | 32'(tgt);
    endfunction
    function automatic logic [31:0] i_loop(input int n);
        return (32'd5 << 29) | (32'(n & 8'hFF) << 16);
    endfunction
    function automatic logic [31:0] i_wait(input int n);
        return (32'd7 << 29) | 32'(n & 16'hFFFF);
    endfunction
    localparam logic [31:0] I_LEND = 32'd6 << 29;
    localparam logic [31:0] I_HALT = 32'd0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] w);
        ld_en = 1'b1; ld_addr = 5'(a); ld_word = w;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Pulse start; edge 0 is the start edge. Records strobe times until done.
    task automatic run(input int maxc, input int restart_at, input bit clr_on_rf);
        n_rf = 0; n_dpu = 0; n_sw = 0; rf_t1 = -1; rf_t2 = -1;
        dpu_t1 = -1; sw_t1 = -1; done_t = -1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int c = 1; c <= maxc; c++) begin
            start = (c == restart_at);
            @(negedge clk);
            cyc = c;
            if (rf_stb) begin
                n_rf++; last_rf = rf_word;
                if (n_rf == 1) rf_t1 = c;
                if (n_rf == 2) rf_t2 = c;
                if (clr_on_rf) flags = '0;
            end
            if (dpu_stb) begin n_dpu++; last_dpu = dpu_word; if (n_dpu == 1) dpu_t1 = c; end
            if (sw_stb) begin n_sw++; last_sw = sw_word; if (n_sw == 1) sw_t1 = c; end
            if (done) begin done_t = c; break; end
        end
        start = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!(rf_stb || dpu_stb || sw_stb || done), "R11 reset quiet", int'(done), 0);

        // R1 R2 R3: sequential program through all three buses
        wr(0, i_cfg(1, 16'h1111)); wr(1, i_cfg(2, 16'h2222));
        wr(2, i_cfg(3, 16'h3333)); wr(3, I_HALT);
        run(50, -1, 0);
        chk(rf_t1 == 1 && last_rf == 16'h1111, "R3 rf word", rf_t1, 1);
        chk(dpu_t1 == 2 && last_dpu == 16'h2222, "R3 dpu word", dpu_t1, 2);
        chk(sw_t1 == 3 && last_sw == 16'h3333, "R2 sw order", sw_t1, 3);
        chk(done_t == 4, "R9 halt timing", done_t, 4);

        // R9: done holds with no strobes, start clears it
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk(done && !(rf_stb || dpu_stb || sw_stb), "R9 done hold", int'(done), 1);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R9 start clears done", int'(done), 0);
        repeat (6) @(negedge clk);

        // R5 R6: loop count sweep
        for (int n = 0; n <= 5; n++) begin
            int k;
            k = (n == 0) ? 1 : n;
            wr(0, i_loop(n)); wr(1, i_cfg(1, 16'h100 + n)); wr(2, I_LEND); wr(3, I_HALT);
            run(100, -1, 0);
            chk(n_rf == k, "R5 loop iterations", n_rf, k);
            chk(done_t == 2 * k + 2, "R6 loop cycles", done_t, 2 * k + 2);
        end

        // R7: nested loops
        for (int a = 1; a <= 3; a++) begin
            for (int b = 1; b <= 3; b++) begin
                wr(0, i_loop(a)); wr(1, i_cfg(2, 1)); wr(2, i_loop(b)); wr(3, i_cfg(3, 2));
                wr(4, I_LEND); wr(5, I_LEND); wr(6, I_HALT);
                run(200, -1, 0);
                chk(n_dpu == a, "R7 outer count", n_dpu, a);
                chk(n_sw == a * b, "R7 inner count", n_sw, a * b);
                chk(done_t == 2 + a * (3 + 2 * b), "R7 nested cycles", done_t, 2 + a * (3 + 2 * b));
            end
        end

        // R4: branch sweep over flag index, polarity and flag pattern
        for (int s = 0; s < 4; s++) begin
            for (int p = 0; p < 2; p++) begin
                wr(0, i_br(s, p, 3)); wr(1, i_cfg(1, 1)); wr(2, I_HALT);
                wr(3, i_cfg(3, 2)); wr(4, I_HALT);
                for (int f = 0; f < 16; f++) begin
                    bit tk;
                    flags = 4'(f);
                    tk = (((f >> s) & 1) == p);
                    run(20, -1, 0);
                    chk((tk ? (n_sw == 1 && n_rf == 0) : (n_rf == 1 && n_sw == 0)) && done_t == 3,
                        "R4 branch path", n_sw, int'(tk));
                end
            end
        end
        flags = '0;

        // R8: wait lengths
        for (int n = 0; n <= 5; n++) begin
            int w;
            w = (n == 5) ? 300 : n;
            wr(0, i_cfg(1, 1)); wr(1, i_wait(w)); wr(2, i_cfg(1, 2)); wr(3, I_HALT);
            run(500, -1, 0);
            chk(rf_t2 - rf_t1 == 2 + w, "R8 wait gap", rf_t2 - rf_t1, 2 + w);
            chk(done_t == 4 + w, "R8 wait done", done_t, 4 + w);
        end

        // R6: loop end on empty stack falls through
        wr(0, I_LEND); wr(1, i_cfg(1, 5)); wr(2, I_HALT);
        run(20, -1, 0);
        chk(n_rf == 1 && rf_t1 == 2, "R6 empty loop end", rf_t1, 2);
        chk(done_t == 3, "R6 empty done", done_t, 3);

        // R10: start during a wait is ignored
        wr(0, i_cfg(1, 1)); wr(1, i_wait(10)); wr(2, i_cfg(1, 2)); wr(3, I_HALT);
        run(100, 5, 0);
        chk(n_rf == 2, "R10 strobe count", n_rf, 2);
        chk(rf_t2 == 13, "R10 no restart", rf_t2, 13);
        chk(done_t == 14, "R10 done time", done_t, 14);

        // R2: address wraps from 31 to 0
        wr(0, i_br(0, 1, 31)); wr(1, I_HALT); wr(31, i_cfg(1, 9));
        flags = 4'b0001;
        run(20, -1, 1);
        chk(n_rf == 1 && last_rf == 16'h9, "R2 wrap strobe", n_rf, 1);
        chk(done_t == 4, "R2 wrap to zero", done_t, 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule